// File: doc/BRIEF.md
# Triggered Multichannel DAC Update Sequencer

This block drives four quad-channel digital-to-analog converters from a single group trigger. When the trigger is accepted, the sixteen signed 16-bit channel words and their enable bits are copied into a shadow store. The words are then written in ascending channel order over a parallel write bus. After the last channel, a single load strobe makes every converter output change together. A one-cycle done pulse closes the sequence.

The time a sequence takes depends on the enable mask. An enabled channel occupies a four-cycle write slot. A disabled channel costs one skip cycle. Six cycles of fixed overhead are added. With every channel enabled, a sequence lasts 70 cycles; with none enabled, it lasts 22. The trigger is level-sensitive. While it stays high, each sequence is followed directly by the next, which gives the highest refresh rate. A trigger that arrives while a sequence is running has no effect unless it is still high in the done cycle.

The controller uses seven states:
- IDLE waits for the trigger.
- PREP is the first overhead cycle.
- SLOT is the write slot of an enabled channel.
- SKIP is the single cycle of a disabled channel.
- LOAD carries the update strobe.
- SETTLE holds for three cycles.
- FIN raises done.

Transitions:
- IDLE→PREP when the trigger is high, capturing the inputs.
- PREP→SLOT or PREP→SKIP, depending on the enable of channel 0.
- SLOT or SKIP → SLOT or SKIP for the next channel.
- SLOT or SKIP → LOAD after channel 15.
- LOAD→SETTLE.
- SETTLE→FIN after three cycles.
- FIN→PREP when the trigger is high, capturing the inputs again.
- FIN→IDLE otherwise.

Top module: `dacseq_top`

## Requirements
- R1: While reset is asserted, and after it is released with the trigger low, busy, write strobe, load strobe and done are all 0.
- R2: A trigger that is high at a clock edge while the block is idle starts a sequence, and busy is 1 from the next cycle on; busy never rises without the trigger having been high at the edge before.
- R3: An enabled channel occupies exactly four cycles, and the write strobe is high only in the first of them, for one cycle.
- R4: A disabled channel occupies exactly one cycle and produces no write strobe.
- R5: Channels are visited in ascending order 0 to 15. With each write strobe, device select equals the channel index divided by four (index bits 3:2) and channel address equals the index modulo four (index bits 1:0).
- R6: A sequence keeps busy high for 6 + 4·A + I cycles, where A is the number of enabled channels and I the number of disabled ones. That is 70 cycles with all enabled and 22 with none.
- R7: The load strobe is high for exactly one cycle, four cycles before done. Done is high for exactly one cycle, in the last busy cycle.
- R8: Channel words and enables are captured when the trigger is accepted. Changing the inputs during a sequence does not change the data written or which channels are written.
- R9: A trigger pulse during a busy cycle other than the done cycle is ignored. A trigger held high starts the next sequence in the cycle after done, with no idle cycle, so done pulses recur every 6 + 4·A + I cycles.
- R10: Channel words are 16-bit two's complement (0x7FFF positive full scale, 0x0000 mid-scale, 0xFFFF one step below mid-scale, 0x8000 negative full scale) and appear unmodified on the write data bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_data_i | input | 256 | Channel words, channel n in bits 16n+15:16n |
| ch_en_i | input | 16 | Per-channel enable, bit n for channel n |
| trig_i | input | 1 | Level-sensitive group trigger |
| wr_dev_o | output | 2 | Converter device select of the current write |
| wr_addr_o | output | 2 | Channel address inside the device |
| wr_data_o | output | 16 | Channel word being written |
| wr_stb_o | output | 1 | Write strobe, one cycle per enabled channel |
| load_o | output | 1 | Common update strobe |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |

## Verification
Some rules are checked by assertions on every cycle:
- Write strobes occur only for channels whose captured enable is set, and are never adjacent.
- Load and done are single-cycle pulses.
- The channel index only ever steps up by one and never wraps mid-sequence.
- The shadow store changes only on a capture.
- Busy rises only after a trigger.

Some behaviours only the directed scenarios can show:
- The exact busy length for a given mask.
- The cycle on which each channel is strobed, with its device, address and data.
- That words changed mid-sequence do not leak into the writes.
- That a stray trigger while busy has no effect.
- The back-to-back period under a held trigger.

// File: rtl/dacseq_pkg.sv
package dacseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_SLOT,
        ST_SKIP,
        ST_LOAD,
        ST_SETTLE,
        ST_FIN
    } seq_state_t;

endpackage

// File: rtl/dacseq_shadow.sv
module dacseq_shadow #(
    parameter int NUM_CH = 16,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cap_i,
    input  logic [NUM_CH*DATA_W-1:0] data_i,
    input  logic [NUM_CH-1:0]        en_i,
    input  logic [IDX_W-1:0]         idx_i,
    output logic [DATA_W-1:0]        word_o,
    output logic [NUM_CH-1:0]        en_vec_o
);

    logic [NUM_CH*DATA_W-1:0] data_q;
    logic [NUM_CH-1:0]        en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            en_q   <= '0;
        end else if (cap_i) begin
            data_q <= data_i;
            en_q   <= en_i;
        end
    end

    assign word_o   = data_q[idx_i*DATA_W +: DATA_W];
    assign en_vec_o = en_q;

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_i |=> ($stable(data_q) && $stable(en_q))); // R8

endmodule

// File: rtl/dacseq_cursor.sv
module dacseq_cursor #(
    parameter int NUM_CH = 16,
    parameter int TMR_W  = 3,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_clr_i,
    input  logic             idx_inc_i,
    input  logic             tmr_clr_i,
    output logic [IDX_W-1:0] idx_o,
    output logic [TMR_W-1:0] tmr_o
);

    logic [IDX_W-1:0] idx_q;
    logic [TMR_W-1:0] tmr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (idx_clr_i) begin
            idx_q <= '0;
        end else if (idx_inc_i) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || tmr_clr_i) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_q + 1'b1;
        end
    end

    assign idx_o = idx_q;
    assign tmr_o = tmr_q;

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_inc_i && !idx_clr_i) |=> (idx_q == $past(idx_q) + 1'b1)); // R5

    AST_IDX_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        idx_inc_i |-> (idx_q != IDX_W'(NUM_CH - 1))); // R5

endmodule

// File: rtl/dacseq_ctrl.sv
module dacseq_ctrl
    import dacseq_pkg::*;
#(
    parameter int NUM_CH     = 16,
    parameter int TMR_W      = 3,
    parameter int SLOT_CYC   = 4,
    parameter int SETTLE_CYC = 3,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic [NUM_CH-1:0] en_vec_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [TMR_W-1:0]  tmr_i,
    output logic              cap_o,
    output logic              idx_clr_o,
    output logic              idx_inc_o,
    output logic              tmr_clr_o,
    output logic              in_slot_o,
    output logic              wr_stb_o,
    output logic              load_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CH - 1);

    seq_state_t state_q, state_n;

    logic             last_ch;
    logic             slot_end;
    logic             settle_end;
    logic [IDX_W-1:0] nxt_idx;
    logic             ch_step;

    assign last_ch    = (idx_i == LAST_IDX);
    assign slot_end   = (tmr_i == TMR_W'(SLOT_CYC - 1));
    assign settle_end = (tmr_i == TMR_W'(SETTLE_CYC - 1));
    assign nxt_idx    = idx_i + 1'b1;
    assign ch_step    = (state_q == ST_SKIP) || ((state_q == ST_SLOT) && slot_end);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // Next state and control outputs
    always_comb begin
        state_n   = state_q;
        cap_o     = 1'b0;
        idx_clr_o = 1'b0;
        idx_inc_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (trig_i) begin
                    state_n   = ST_PREP;
                    cap_o     = 1'b1;
                    idx_clr_o = 1'b1;
                end
            end
            ST_PREP: begin
                state_n = en_vec_i[idx_i] ? ST_SLOT : ST_SKIP;
            end
            ST_SLOT, ST_SKIP: begin
                if (ch_step) begin
                    if (last_ch) begin
                        state_n = ST_LOAD;
                    end else begin
                        idx_inc_o = 1'b1;
                        state_n   = en_vec_i[nxt_idx] ? ST_SLOT : ST_SKIP;
                    end
                end
            end
            ST_LOAD: begin
                state_n = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (settle_end) begin
                    state_n = ST_FIN;
                end
            end
            ST_FIN: begin
                if (trig_i) begin
                    state_n   = ST_PREP;
                    cap_o     = 1'b1;
                    idx_clr_o = 1'b1;
                end else begin
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
        tmr_clr_o = (state_n != state_q) || ch_step;
    end

    // Port outputs
    always_comb begin
        in_slot_o = (state_q == ST_SLOT);
        wr_stb_o  = (state_q == ST_SLOT) && (tmr_i == '0);
        load_o    = (state_q == ST_LOAD);
        busy_o    = (state_q != ST_IDLE);
        done_o    = (state_q == ST_FIN);
    end

    AST_STB_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> en_vec_i[idx_i]); // R4

    AST_STB_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |=> !wr_stb_o); // R3

    AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7

    AST_START_ON_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(trig_i)); // R2

endmodule

// File: rtl/dacseq_top.sv
module dacseq_top #(
    parameter int NUM_DEV    = 4,
    parameter int CH_PER_DEV = 4,
    parameter int DATA_W     = 16,
    parameter int SLOT_CYC   = 4,
    parameter int SETTLE_CYC = 3,
    localparam int NUM_CH  = NUM_DEV * CH_PER_DEV,
    localparam int IDX_W   = $clog2(NUM_CH),
    localparam int DEV_W   = $clog2(NUM_DEV),
    localparam int ADDR_W  = $clog2(CH_PER_DEV),
    localparam int TMR_MAX = (SLOT_CYC > SETTLE_CYC) ? SLOT_CYC : SETTLE_CYC,
    localparam int TMR_W   = $clog2(TMR_MAX) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH*DATA_W-1:0] ch_data_i,
    input  logic [NUM_CH-1:0]        ch_en_i,
    input  logic                     trig_i,
    output logic [DEV_W-1:0]         wr_dev_o,
    output logic [ADDR_W-1:0]        wr_addr_o,
    output logic [DATA_W-1:0]        wr_data_o,
    output logic                     wr_stb_o,
    output logic                     load_o,
    output logic                     busy_o,
    output logic                     done_o
);

    logic              cap;
    logic              idx_clr;
    logic              idx_inc;
    logic              tmr_clr;
    logic              in_slot;
    logic [IDX_W-1:0]  idx;
    logic [TMR_W-1:0]  tmr;
    logic [DATA_W-1:0] sh_word;
    logic [NUM_CH-1:0] sh_en;

    dacseq_shadow #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W)
    ) shadow_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_i    (cap),
        .data_i   (ch_data_i),
        .en_i     (ch_en_i),
        .idx_i    (idx),
        .word_o   (sh_word),
        .en_vec_o (sh_en)
    );

    dacseq_cursor #(
        .NUM_CH (NUM_CH),
        .TMR_W  (TMR_W)
    ) cursor_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_clr_i (idx_clr),
        .idx_inc_i (idx_inc),
        .tmr_clr_i (tmr_clr),
        .idx_o     (idx),
        .tmr_o     (tmr)
    );

    dacseq_ctrl #(
        .NUM_CH     (NUM_CH),
        .TMR_W      (TMR_W),
        .SLOT_CYC   (SLOT_CYC),
        .SETTLE_CYC (SETTLE_CYC)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_i    (trig_i),
        .en_vec_i  (sh_en),
        .idx_i     (idx),
        .tmr_i     (tmr),
        .cap_o     (cap),
        .idx_clr_o (idx_clr),
        .idx_inc_o (idx_inc),
        .tmr_clr_o (tmr_clr),
        .in_slot_o (in_slot),
        .wr_stb_o  (wr_stb_o),
        .load_o    (load_o),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

    // Write bus, valid across the whole slot of an enabled channel
    assign wr_dev_o  = in_slot ? DEV_W'(idx / IDX_W'(CH_PER_DEV)) : '0;
    assign wr_addr_o = in_slot ? ADDR_W'(idx % IDX_W'(CH_PER_DEV)) : '0;
    assign wr_data_o = in_slot ? sh_word : '0;

endmodule

// File: tb/dacseq_top_tb_top.sv
module dacseq_top_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [255:0] ch_data = '0;
    logic [15:0]  ch_en = '0;
    logic         trig = 1'b0;
    logic [1:0]   wr_dev_o;
    logic [1:0]   wr_addr_o;
    logic [15:0]  wr_data_o;
    logic         wr_stb_o;
    logic         load_o;
    logic         busy_o;
    logic         done_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] vals [16];

    always #5 clk = ~clk;

    dacseq_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_data_i (ch_data),
        .ch_en_i   (ch_en),
        .trig_i    (trig),
        .wr_dev_o  (wr_dev_o),
        .wr_addr_o (wr_addr_o),
        .wr_data_o (wr_data_o),
        .wr_stb_o  (wr_stb_o),
        .load_o    (load_o),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

    task automatic chk(input string req, input bit ok, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] pack_vals();
        logic [255:0] p;
        for (int i = 0; i < 16; i++) p[i*16 +: 16] = vals[i];
        return p;
    endfunction

    function automatic int seq_len(input logic [15:0] m);
        int n = 6;
        for (int i = 0; i < 16; i++) n += m[i] ? 4 : 1;
        return n;
    endfunction

    // R1: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        trig  = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 in reset", {busy_o, wr_stb_o, load_o, done_o} == 4'b0,
            {busy_o, wr_stb_o, load_o, done_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 after reset", {busy_o, wr_stb_o, load_o, done_o} == 4'b0,
            {busy_o, wr_stb_o, load_o, done_o}, 0);
    endtask

    // One triggered sequence; checks R2..R10 against the mask and vals
    task automatic t_seq(input string tag, input logic [15:0] mask,
                         input bit mutate, input bit stray);
        int start [16];
        int acc = 2;
        int n_exp = seq_len(mask);
        int cyc;
        int nstb = 0;
        int ld_cyc = -1;
        int dn_cyc = -1;
        logic [255:0] pk = pack_vals();
        for (int i = 0; i < 16; i++) begin
            start[i] = acc;
            acc += mask[i] ? 4 : 1;
        end
        @(negedge clk);
        ch_data = pk;
        ch_en   = mask;
        trig    = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        cyc  = 1;
        chk({tag, " R2 busy after trigger"}, busy_o == 1'b1, busy_o, 1);
        while (busy_o && cyc < 300) begin
            if (wr_stb_o) begin
                int ch = -1;
                int seen = 0;
                for (int i = 0; i < 16; i++) begin
                    if (mask[i]) begin
                        if (seen == nstb && ch < 0) ch = i;
                        seen++;
                    end
                end
                if (ch < 0) begin
                    chk({tag, " R4 strobe beyond enabled channels"}, 1'b0, nstb, $countones(mask));
                end else begin
                    logic [35:0] a = {8'(cyc), 2'(wr_dev_o), 2'(wr_addr_o), wr_data_o, 8'(0)};
                    logic [35:0] e = {8'(start[ch]), 2'(ch / 4), 2'(ch % 4), vals[ch], 8'(0)};
                    chk({tag, " R3 R5 R10 strobe cycle/dev/addr/data"}, a == e, a, e);
                end
                nstb++;
            end
            if (load_o) begin
                if (ld_cyc >= 0) chk({tag, " R7 second load"}, 1'b0, cyc, ld_cyc);
                ld_cyc = cyc;
            end
            if (done_o) dn_cyc = cyc;
            if (mutate && cyc == 3) begin
                ch_data = ~pk;
                ch_en   = ~mask;
            end
            trig = (stray && cyc == 5);
            @(negedge clk);
            cyc++;
        end
        trig = 1'b0;
        chk({tag, " R6 busy length"}, (cyc - 1) == n_exp, cyc - 1, n_exp);
        chk({tag, " R4 strobe count"}, nstb == $countones(mask), nstb, $countones(mask));
        chk({tag, " R7 load cycle"}, ld_cyc == n_exp - 4, ld_cyc, n_exp - 4);
        chk({tag, " R7 done cycle"}, dn_cyc == n_exp, dn_cyc, n_exp);
        if (stray) begin
            for (int k = 0; k < 3; k++) begin
                chk({tag, " R9 stray trigger ignored"}, busy_o == 1'b0, busy_o, 0);
                @(negedge clk);
            end
        end
    endtask

    // R9: held trigger runs back-to-back
    task automatic t_held(input logic [15:0] mask);
        int n_exp = seq_len(mask);
        int dones [3];
        int nd = 0;
        int cyc = 1;
        bit gap = 1'b0;
        @(negedge clk);
        ch_data = pack_vals();
        ch_en   = mask;
        trig    = 1'b1;
        @(negedge clk);
        while (nd < 3 && cyc < 400) begin
            if (!busy_o) gap = 1'b1;
            if (done_o) begin
                dones[nd] = cyc;
                nd++;
                if (nd == 3) trig = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        chk("R9 no idle gap under held trigger", gap == 1'b0, gap, 0);
        chk("R9 done count", nd == 3, nd, 3);
        chk("R9 first period", dones[0] == n_exp, dones[0], n_exp);
        chk("R9 second period", dones[1] - dones[0] == n_exp, dones[1] - dones[0], n_exp);
        chk("R9 third period", dones[2] - dones[1] == n_exp, dones[2] - dones[1], n_exp);
        chk("R9 idle after release", busy_o == 1'b0, busy_o, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();

        // All enabled, full-scale codes included (R6 70 cycles, R10)
        vals[0] = 16'h7FFF; vals[1] = 16'h0000; vals[2] = 16'hFFFF; vals[3] = 16'h8000;
        vals[4] = 16'h7FFE; vals[5] = 16'h0001; vals[6] = 16'h8001; vals[7] = 16'h1234;
        for (int i = 8; i < 16; i++) vals[i] = 16'(16'hA000 + i * 16'h0111);
        t_seq("all_on", 16'hFFFF, 1'b0, 1'b0);

        // None enabled (R4, R6 22 cycles)
        t_seq("all_off", 16'h0000, 1'b0, 1'b0);

        // Sparse mask with inputs changed mid-sequence (R8)
        for (int i = 0; i < 16; i++) vals[i] = 16'(16'h0F00 ^ (i * 16'h1357));
        t_seq("sparse_mutate", 16'hA5C3, 1'b1, 1'b0);

        // Edge channels only, with a stray trigger while busy (R9)
        t_seq("edges_stray", 16'h8001, 1'b0, 1'b1);

        // Held trigger (R9)
        t_held(16'h0F0F);

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule